// File: doc/BRIEF.md
# Reloadable Timer with Single-Shot Pulse-Width Capture

This block is a 16-bit up-counter that serves as an interval timer, as an event counter driven by an external pin, or as a one-shot pulse-width meter. Software sets it up through byte-wide register writes. It writes a preload value in two halves, then writes a control byte that picks the mode, the active edge and the run bit. The live count can be read back one byte at a time. When the counter passes the all-ones value it reloads the preload value instead of rolling to zero, and it raises a sticky overflow request.

In pulse-width mode the counter waits for the active transition on the pin. It then counts time-base ticks while the pin stays at its active level. When the pin returns to its idle level, the counter stops and clears its own run bit. Further pin activity leaves the result untouched until software sets the run bit again. The pin input is assumed to be already synchronized. The time base arrives as a one-cycle enable, `tick_en`. The register interface is a plain write strobe plus a combinational read mux. It has no back-pressure, so every write completes in the cycle it is presented.

Top module: `reltmr_top`

## Requirements
- R1: After reset the count is 0000h, the control byte reads 00h, the preload is 0000h and `ovf_irq` is low.
- R2: A write to address 0 (preload low) only fills a shadow byte and leaves the active preload unchanged. A write to address 1 (preload high) commits {written byte, shadow byte} as the 16-bit preload at that clock edge.
- R3: A control write (address 2) whose run bit (bit 3) is 1 while the run bit is currently 0 copies the committed preload into the count at that same edge. A control write with run=1 while already running does not reload the count.
- R4: With mode field (bits 1:0) = 10b and run = 1, the count rises by one at every clock edge where `tick_en` is high.
- R5: With mode = 01b and run = 1, the count rises by one at every active transition of `ext_pin`. Control bit 2 selects the edge: 0 means rising, 1 means falling. `tick_en` has no effect in this mode.
- R6: With mode = 11b and run = 1, measurement begins at the active transition of `ext_pin`. From then on, the count rises by one for every clock edge with `tick_en` high at which the pin is at its active level, the starting edge included. The edge at which the pin returns to idle stops counting and clears the run bit.
- R7: After a pulse measurement the count is held through any later pin activity. Setting the run bit again reloads the preload and arms a new measurement.
- R8: With run = 0, or with mode = 00b, the count does not change on ticks or pin edges.
- R9: An increment from FFFFh loads the committed preload into the count and sets `ovf_irq`.
- R10: `ovf_irq` stays high until an `ovf_ack` cycle clears it. If an overflow and an acknowledge occur in the same cycle, the flag stays set.
- R11: The read data depends on `rd_addr`. Address 0 returns the count low byte, address 1 the count high byte, and address 2 the control byte {0000b, run, edge, mode}. Address 3 returns 00h. Control bits 7:4 are ignored on write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 preload low, 1 preload high, 2 control |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| tick_en | input | 1 | Time-base enable, one clock per tick |
| ext_pin | input | 1 | Synchronized external event/gate pin |
| ovf_ack | input | 1 | Clears the overflow request |
| ovf_irq | output | 1 | Sticky overflow request |
| run | output | 1 | Current run bit |

## Verification
Every result appears at the clock edge that samples its cause, with no extra pipeline stage. A register write, a tick, a pin transition or an overflow changes the count, preload, run bit or `ovf_irq` at the edge where the strobe or pin level is sampled. Read data follows `rd_addr` combinationally. The bench drives inputs at the falling edge and holds each stimulus for an exact number of rising edges. It then reads back one falling edge later plus a small delay, so each expected value counts exactly the edges the stimulus was present for. Pulse widths are counted in rising edges that see the pin at its active level, with the starting edge included and the returning edge excluded.

// File: rtl/reltmr_pkg.sv
package reltmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ADDR_PRE_LO = 2'd0;
  localparam logic [1:0] ADDR_PRE_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int CTRL_MODE_LSB = 0;
  localparam int CTRL_EDGE_BIT = 2;
  localparam int CTRL_RUN_BIT  = 3;
endpackage

// File: rtl/reltmr_preload.sv
module reltmr_preload #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  preload
);
  logic [BYTE_W-1:0] shadow_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_lo <= '0;
      preload   <= '0;
    end else begin
      if (wr_lo) shadow_lo <= wr_data;
      if (wr_hi) preload   <= {wr_data, shadow_lo};
    end
  end

  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(preload)); // R2
  AST_PRELOAD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> preload[CNT_W-1:BYTE_W] == $past(wr_data)); // R2
endmodule

// File: rtl/reltmr_ctrl.sv
module reltmr_ctrl
  import reltmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              hw_stop,
  output tmr_mode_e         mode,
  output logic              edge_fall,
  output logic              run,
  output logic              start
);
  logic run_req;

  assign run_req = wr_data[CTRL_RUN_BIT];
  assign start   = wr_ctrl && run_req && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= MODE_OFF;
      edge_fall <= 1'b0;
      run       <= 1'b0;
    end else if (wr_ctrl) begin
      mode      <= tmr_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
      edge_fall <= wr_data[CTRL_EDGE_BIT];
      run       <= run_req;
    end else if (hw_stop) begin
      run <= 1'b0;
    end
  end

  AST_HW_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stop && !wr_ctrl |=> !run); // R6
  AST_RUN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_ctrl |=> !run); // R7
endmodule

// File: rtl/reltmr_edge.sv
module reltmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_pin,
  input  logic edge_fall,
  output logic act_edge,
  output logic end_edge
);
  logic pin_q;
  logic rose;
  logic fell;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= ext_pin;
  end

  assign rose     = ext_pin && !pin_q;
  assign fell     = !ext_pin && pin_q;
  assign act_edge = edge_fall ? fell : rose;
  assign end_edge = edge_fall ? rose : fell;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_edge && end_edge)); // R5
endmodule

// File: rtl/reltmr_core.sv
module reltmr_core
  import reltmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  tmr_mode_e        mode,
  input  logic             tick_en,
  input  logic             act_edge,
  input  logic             end_edge,
  input  logic [CNT_W-1:0] preload,
  input  logic             ovf_ack,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             hw_stop
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic meas;
  logic pulse_on;
  logic inc;
  logic wrap;

  assign pulse_on = run && (mode == MODE_PULSE);
  assign hw_stop  = pulse_on && meas && end_edge;

  always_comb begin
    inc = 1'b0;
    if (run) begin
      unique case (mode)
        MODE_TIMER: inc = tick_en;
        MODE_EVENT: inc = act_edge;
        MODE_PULSE: inc = tick_en && (meas ? !end_edge : act_edge);
        default:    inc = 1'b0;
      endcase
    end
  end

  assign wrap = inc && (count == ALL_ONES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      meas     <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (start)      count <= preload;
      else if (wrap)  count <= preload;
      else if (inc)   count <= count + 1'b1;

      if (!pulse_on)                 meas <= 1'b0;
      else if (!meas && act_edge)    meas <= 1'b1;
      else if (meas && end_edge)     meas <= 1'b0;

      if (wrap)         ovf_flag <= 1'b1;
      else if (ovf_ack) ovf_flag <= 1'b0;
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count == $past(preload)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || mode == MODE_OFF) && !start |=> $stable(count)); // R8
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    run && mode == MODE_TIMER && tick_en && !start && count == ALL_ONES
      |=> ovf_flag && count == $past(preload)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_ack |=> ovf_flag); // R10
endmodule

// File: rtl/reltmr_top.sv
module reltmr_top
  import reltmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W,
  localparam int NBYTE = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              tick_en,
  input  logic              ext_pin,
  input  logic              ovf_ack,
  output logic              ovf_irq,
  output logic              run
);
  logic              wr_lo, wr_hi, wr_ctrl;
  logic [CNT_W-1:0]  preload;
  logic [CNT_W-1:0]  count;
  tmr_mode_e         mode;
  logic              edge_fall;
  logic              start;
  logic              hw_stop;
  logic              act_edge, end_edge;
  logic [BYTE_W-1:0] cnt_byte [NBYTE];
  logic [BYTE_W-1:0] ctrl_rd;

  assign wr_lo   = wr_en && (wr_addr == ADDR_PRE_LO);
  assign wr_hi   = wr_en && (wr_addr == ADDR_PRE_HI);
  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);

  reltmr_preload #(.BYTE_W(BYTE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .preload(preload)
  );

  reltmr_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .hw_stop(hw_stop), .mode(mode), .edge_fall(edge_fall),
    .run(run), .start(start)
  );

  reltmr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_fall(edge_fall),
    .act_edge(act_edge), .end_edge(end_edge)
  );

  reltmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .mode(mode),
    .tick_en(tick_en), .act_edge(act_edge), .end_edge(end_edge),
    .preload(preload), .ovf_ack(ovf_ack), .count(count),
    .ovf_flag(ovf_irq), .hw_stop(hw_stop)
  );

  for (genvar gi = 0; gi < NBYTE; gi++) begin : g_bytes
    assign cnt_byte[gi] = count[gi*BYTE_W +: BYTE_W];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_MODE_LSB +: 2] = mode;
    ctrl_rd[CTRL_EDGE_BIT]      = edge_fall;
    ctrl_rd[CTRL_RUN_BIT]       = run;
  end

  always_comb begin
    unique case (rd_addr)
      2'd0:    rd_data = cnt_byte[0];
      2'd1:    rd_data = cnt_byte[1];
      2'd2:    rd_data = ctrl_rd;
      default: rd_data = '0;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !ovf_irq && !run); // R1
endmodule

// File: tb/sim_reltmr_top.sv
module sim_reltmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tick_en = 1'b0;
  logic       ext_pin = 1'b0;
  logic       ovf_ack = 1'b0;
  logic       ovf_irq;
  logic       run;

  int n_chk = 0;
  int n_bad = 0;

  reltmr_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_en(tick_en), .ext_pin(ext_pin), .ovf_ack(ovf_ack),
    .ovf_irq(ovf_irq), .run(run)
  );

  always #5 clk = ~clk;

  // {preload, ticks, expected count, expected irq}
  localparam logic [48:0] VEC [5] = '{
    {16'h0000, 16'd5,  16'h0005, 1'b0},
    {16'h1234, 16'd16, 16'h1244, 1'b0},
    {16'hFFFD, 16'd3,  16'hFFFD, 1'b1},
    {16'hFFF0, 16'd20, 16'hFFF4, 1'b1},
    {16'h00FF, 16'd1,  16'h0100, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    c = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pin_pulse(input logic lvl, input int n);
    @(negedge clk);
    ext_pin = lvl;
    repeat (n) @(negedge clk);
    ext_pin = ~lvl;
    repeat (2) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk);
    ovf_ack = 1'b1;
    @(negedge clk);
    ovf_ack = 1'b0;
  endtask

  task automatic set_pre(input logic [15:0] p);
    wr(2'd0, p[7:0]);
    wr(2'd1, p[15:8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] c;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R11 reset state and read map
    rd_cnt(c);          chk("R1 count", c, 16'h0000);
    rd(2'd2, b);        chk("R1 ctrl", b, 8'h00);
    chk("R1 irq", ovf_irq, 1'b0);
    wr(2'd2, 8'h08);    rd_cnt(c); chk("R1 preload zero", c, 16'h0000);
    wr(2'd2, 8'h00);

    // vector table: timer mode, R4 and R9
    foreach (VEC[i]) begin
      ack();
      set_pre(VEC[i][48:33]);
      wr(2'd2, 8'h0A);
      ticks(int'(VEC[i][32:17]));
      wr(2'd2, 8'h02);
      rd_cnt(c);
      chk($sformatf("R4/R9 vec%0d count", i), c, VEC[i][16:1]);
      chk($sformatf("R9 vec%0d irq", i), ovf_irq, VEC[i][0]);
    end

    // R2 shadow low byte
    set_pre(16'h12AA);
    wr(2'd0, 8'h55);
    wr(2'd2, 8'h0A); rd_cnt(c); chk("R2 low alone no commit", c, 16'h12AA);
    wr(2'd2, 8'h02);
    wr(2'd1, 8'h77);
    wr(2'd2, 8'h0A); rd_cnt(c); chk("R2 high commits", c, 16'h7755);

    // R3 rewrite run while running: no reload
    ticks(3);
    wr(2'd2, 8'h0A); rd_cnt(c); chk("R3 no reload", c, 16'h7758);
    wr(2'd2, 8'h02);

    // R8 mode off with run, and run low in event mode
    set_pre(16'h0040);
    wr(2'd2, 8'h08); ticks(4); pin_pulse(1'b1, 2);
    rd_cnt(c); chk("R8 mode off holds", c, 16'h0040);
    wr(2'd2, 8'h01); pin_pulse(1'b1, 2); ticks(2);
    rd_cnt(c); chk("R8 run low holds", c, 16'h0040);

    // R5 event counting, rising then falling
    set_pre(16'h0000);
    wr(2'd2, 8'h09);
    tick_en = 1'b1;
    pin_pulse(1'b1, 1); pin_pulse(1'b1, 3); pin_pulse(1'b1, 2);
    tick_en = 1'b0;
    rd_cnt(c); chk("R5 rising edges", c, 16'h0003);
    wr(2'd2, 8'h05);
    wr(2'd2, 8'h0D);
    @(negedge clk); ext_pin = 1'b1; @(negedge clk);
    rd_cnt(c); chk("R5 falling ignores rise", c, 16'h0000);
    ext_pin = 1'b0; @(negedge clk);
    rd_cnt(c); chk("R5 falling counts", c, 16'h0001);
    wr(2'd2, 8'h05);

    // R6 pulse-width measurement, rising active
    set_pre(16'h0100);
    wr(2'd2, 8'h0B);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_cnt(c); chk("R6 waits for edge", c, 16'h0100);
    pin_pulse(1'b1, 6);
    rd_cnt(c); chk("R6 width", c, 16'h0106);
    rd(2'd2, b); chk("R6 run cleared", b, 8'h03);

    // R7 hold, then re-arm
    pin_pulse(1'b1, 4);
    rd_cnt(c); chk("R7 result held", c, 16'h0106);
    wr(2'd2, 8'h0B);
    rd_cnt(c); chk("R7 rearm reloads", c, 16'h0100);
    pin_pulse(1'b1, 3);
    rd_cnt(c); chk("R7 second width", c, 16'h0103);

    // R6 falling-active pulse
    @(negedge clk); ext_pin = 1'b1; @(negedge clk);
    wr(2'd2, 8'h0F);
    pin_pulse(1'b0, 2);
    rd_cnt(c); chk("R6 low pulse width", c, 16'h0102);
    chk("R6 run pin", run, 1'b0);
    tick_en = 1'b0;
    ext_pin = 1'b0;
    wr(2'd2, 8'h03);

    // R10 sticky flag and ack priority
    ack();
    set_pre(16'hFFFF);
    wr(2'd2, 8'h0A); ticks(1); wr(2'd2, 8'h02);
    repeat (3) @(negedge clk);
    chk("R10 sticky", ovf_irq, 1'b1);
    ack();
    chk("R10 ack clears", ovf_irq, 1'b0);
    wr(2'd2, 8'h0A);
    @(negedge clk); tick_en = 1'b1; ovf_ack = 1'b1;
    @(negedge clk); tick_en = 1'b0; ovf_ack = 1'b0;
    chk("R10 set wins", ovf_irq, 1'b1);
    wr(2'd2, 8'h02);

    // R11 control readback and unused bits
    wr(2'd2, 8'hF6); rd(2'd2, b); chk("R11 ctrl upper ignored", b, 8'h06);
    rd(2'd3, b); chk("R11 addr3 zero", b, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule